// File: doc/BRIEF.md
# Pointer Register Address Generator

This block turns a pointer register and a displacement into a 32-bit memory address for a load or store, and hands back the modified pointer when the chosen mode changes it. It holds 32 pointer registers in two banks of 16. Bit 4 of a register index selects the bank and bits 3:0 select the entry. The unit offers six addressing modes. Plain indirect uses the pointer as it is. Post-increment and post-decrement use the old value and then step the pointer. Pre-increment and pre-decrement step the pointer and use the new value. Pre-offset adds the step to form the address but does not write the pointer back.

A request is a strobe plus a mode code, a register index, a displacement, a flag that says whether a displacement was supplied, and an access size. The address and the writeback are combinational in the request cycle, and the register file takes the new pointer on the next clock edge. A separate load port lets the surrounding logic set a pointer. An observation port reads any pointer without side effects.

Top module: `ptr_agu`

## Requirements
- R1: After reset every pointer register reads zero on the observation port.
- R2: A load port write sets the chosen register on the next edge. If the load port and a pointer writeback name the same register in the same cycle, the loaded value is kept.
- R3: Mode 0 (plain indirect), and the unused codes 6 and 7, give an address equal to the pointer and no writeback.
- R4: Mode 1 (post-increment) gives the old pointer as the address and writes back pointer plus step.
- R5: Mode 2 (post-decrement) gives the old pointer as the address and writes back pointer minus step.
- R6: Mode 3 (pre-increment) writes back pointer plus step, and the address equals that new value.
- R7: Mode 4 (pre-decrement) writes back pointer minus step, and the address equals that new value.
- R8: Mode 5 (pre-offset) gives pointer plus step as the address and leaves the pointer unchanged.
- R9: The step is the displacement shifted left by the size code (size 0 gives x1, 1 gives x2, 2 and 3 give x4). When the supplied-flag is low, the displacement is taken as 1.
- R10: All address and pointer arithmetic wraps modulo 2^32.
- R11: A writeback is visible to a request or observation of the same register in the next cycle. Indices 0 and 16 name different registers.
- R12: With the strobe low, `ea_valid` and `wb_en` stay low and no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load port write enable |
| ld_idx | input | 5 | Load port register index |
| ld_data | input | 32 | Load port value |
| agu_stb | input | 1 | Address request strobe |
| agu_mode | input | 3 | Addressing mode code |
| agu_idx | input | 5 | Pointer register index |
| agu_disp | input | 5 | Unsigned displacement in access units |
| agu_disp_ok | input | 1 | Displacement supplied; low means use 1 |
| agu_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| ea | output | 32 | Effective address |
| ea_valid | output | 1 | Address valid this cycle |
| wb_en | output | 1 | Pointer writeback taken this cycle |
| wb_idx | output | 5 | Index of the pointer being written back |
| wb_data | output | 32 | Updated pointer value |
| obs_idx | input | 5 | Observation port index |
| obs_data | output | 32 | Observed pointer value |

## Verification
Two functions can land in the same cycle: a modifying address request writing back its pointer, and a load port write. The bench provokes this with random load traffic that runs alongside random requests. It also runs a directed case where both target the same register. Its reference model applies the writeback first and the load second, so the load wins. It then judges the result through the observation port and through the next request on that register. A second overlap is covered as well: a writeback followed at once by a request to the same pointer, which must see the stepped value.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [2:0] {
      AM_IND     = 3'd0,
      AM_POSTINC = 3'd1,
      AM_POSTDEC = 3'd2,
      AM_PREINC  = 3'd3,
      AM_PREDEC  = 3'd4,
      AM_OFFSET  = 3'd5
   } agu_mode_e;

   localparam int unsigned MODE_W = 3;
   localparam int unsigned SIZE_W = 2;
endpackage

// File: rtl/agu_calc.sv
module agu_calc
   import agu_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DISP_W   = 5,
   parameter bit          SCALE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic              disp_ok_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic [ADDR_W-1:0] upd_o,
   output logic              wb_req_o
);
   localparam int unsigned PAD_W = ADDR_W - DISP_W;

   if (DISP_W >= ADDR_W) begin : g_bad_disp
      $error("agu_calc: DISP_W must be below ADDR_W");
   end

   logic [DISP_W-1:0] disp_sel;
   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] plus;
   logic [ADDR_W-1:0] minus;

   assign disp_sel = disp_ok_i ? disp_i : DISP_W'(1);
   assign disp_ext = {{PAD_W{1'b0}}, disp_sel};

   if (SCALE_EN) begin : g_scale
      always_comb begin
         unique case (size_i)
            2'd0:    step = disp_ext;
            2'd1:    step = disp_ext << 1;
            default: step = disp_ext << 2;
         endcase
      end
   end else begin : g_noscale
      assign step = disp_ext;
   end

   assign plus  = base_i + step;
   assign minus = base_i - step;

   always_comb begin
      ea_o     = base_i;
      upd_o    = base_i;
      wb_req_o = 1'b0;
      case (mode_i)
         AM_POSTINC: begin upd_o = plus;  wb_req_o = 1'b1; end
         AM_POSTDEC: begin upd_o = minus; wb_req_o = 1'b1; end
         AM_PREINC:  begin upd_o = plus;  ea_o = plus;  wb_req_o = 1'b1; end
         AM_PREDEC:  begin upd_o = minus; ea_o = minus; wb_req_o = 1'b1; end
         AM_OFFSET:  begin ea_o = plus; end
         default:    ;
      endcase
   end

   a_r3_indirect_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && (mode_i == AM_IND || mode_i > AM_OFFSET)) |-> (!wb_req_o && ea_o == base_i));
   a_r4_post_uses_old: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && (mode_i == AM_POSTINC || mode_i == AM_POSTDEC)) |-> (ea_o == base_i && wb_req_o));
   a_r6_pre_uses_new: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && (mode_i == AM_PREINC || mode_i == AM_PREDEC)) |-> (ea_o == upd_o && wb_req_o));
   a_r8_offset_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && mode_i == AM_OFFSET) |-> (!wb_req_o && upd_o == base_i));
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_a_i,
   input  logic [$clog2(DEPTH)-1:0] widx_a_i,
   input  logic [ADDR_W-1:0]        wdata_a_i,
   input  logic                     we_b_i,
   input  logic [$clog2(DEPTH)-1:0] widx_b_i,
   input  logic [ADDR_W-1:0]        wdata_b_i,
   input  logic [$clog2(DEPTH)-1:0] ra_idx_i,
   output logic [ADDR_W-1:0]        ra_data_o,
   input  logic [$clog2(DEPTH)-1:0] rb_idx_i,
   output logic [ADDR_W-1:0]        rb_data_o
);
   localparam int unsigned IW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("ptr_bank: DEPTH must be a power of two of at least 2");
   end

   logic [ADDR_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!rst_n)
            mem_q[i] <= '0;
         else if (we_a_i && widx_a_i == IW'(i))
            mem_q[i] <= wdata_a_i;
         else if (we_b_i && widx_b_i == IW'(i))
            mem_q[i] <= wdata_b_i;
      end
   end

   assign ra_data_o = mem_q[ra_idx_i];
   assign rb_data_o = mem_q[rb_idx_i];

   a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      we_a_i |=> (mem_q[$past(widx_a_i)] == $past(wdata_a_i)));
   a_r11_wb_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we_b_i && !(we_a_i && widx_a_i == widx_b_i)) |=> (mem_q[$past(widx_b_i)] == $past(wdata_b_i)));
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
   import agu_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DISP_W     = 5,
   parameter int unsigned NUM_BANKS  = 2,
   parameter int unsigned BANK_DEPTH = 16,
   parameter bit          SCALE_EN   = 1'b1
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     ld_en,
   input  logic [$clog2(NUM_BANKS*BANK_DEPTH)-1:0]  ld_idx,
   input  logic [ADDR_W-1:0]                        ld_data,
   input  logic                                     agu_stb,
   input  logic [2:0]                               agu_mode,
   input  logic [$clog2(NUM_BANKS*BANK_DEPTH)-1:0]  agu_idx,
   input  logic [DISP_W-1:0]                        agu_disp,
   input  logic                                     agu_disp_ok,
   input  logic [1:0]                               agu_size,
   output logic [ADDR_W-1:0]                        ea,
   output logic                                     ea_valid,
   output logic                                     wb_en,
   output logic [$clog2(NUM_BANKS*BANK_DEPTH)-1:0]  wb_idx,
   output logic [ADDR_W-1:0]                        wb_data,
   input  logic [$clog2(NUM_BANKS*BANK_DEPTH)-1:0]  obs_idx,
   output logic [ADDR_W-1:0]                        obs_data
);
   localparam int unsigned NREG = NUM_BANKS * BANK_DEPTH;
   localparam int unsigned IW   = $clog2(NREG);
   localparam int unsigned EW   = $clog2(BANK_DEPTH);
   localparam int unsigned BW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   if (NUM_BANKS < 2 || (1 << $clog2(NUM_BANKS)) != NUM_BANKS) begin : g_bad_banks
      $error("ptr_agu: NUM_BANKS must be a power of two of at least 2");
   end

   logic [ADDR_W-1:0] agu_rd [NUM_BANKS];
   logic [ADDR_W-1:0] obs_rd [NUM_BANKS];
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] upd;
   logic              wb_req;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic we_ld, we_wb;
      assign we_ld = ld_en && (ld_idx[IW-1:EW] == BW'(b));
      assign we_wb = wb_en && (agu_idx[IW-1:EW] == BW'(b));
      ptr_bank #(.ADDR_W(ADDR_W), .DEPTH(BANK_DEPTH)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .we_a_i    (we_ld),
         .widx_a_i  (ld_idx[EW-1:0]),
         .wdata_a_i (ld_data),
         .we_b_i    (we_wb),
         .widx_b_i  (agu_idx[EW-1:0]),
         .wdata_b_i (upd),
         .ra_idx_i  (agu_idx[EW-1:0]),
         .ra_data_o (agu_rd[b]),
         .rb_idx_i  (obs_idx[EW-1:0]),
         .rb_data_o (obs_rd[b])
      );
   end

   assign base     = agu_rd[agu_idx[IW-1:EW]];
   assign obs_data = obs_rd[obs_idx[IW-1:EW]];

   agu_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SCALE_EN(SCALE_EN)) u_calc (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_i     (agu_stb),
      .mode_i    (agu_mode),
      .base_i    (base),
      .disp_i    (agu_disp),
      .disp_ok_i (agu_disp_ok),
      .size_i    (agu_size),
      .ea_o      (ea),
      .upd_o     (upd),
      .wb_req_o  (wb_req)
   );

   assign ea_valid = agu_stb;
   assign wb_en    = agu_stb && wb_req;
   assign wb_idx   = agu_idx;
   assign wb_data  = upd;

   a_r11_next_sees_new: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && !(ld_en && ld_idx == agu_idx) && agu_stb) ##1 (agu_idx == $past(agu_idx))
      |-> (base == $past(wb_data)));
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!agu_stb && !ld_en) |=> (obs_data == $past(obs_rd[obs_idx[IW-1:EW]]) || obs_idx != $past(obs_idx)));
endmodule

// File: tb/ptr_agu_test.sv
module ptr_agu_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ld_en;
   logic [4:0]  ld_idx;
   logic [31:0] ld_data;
   logic        agu_stb;
   logic [2:0]  agu_mode;
   logic [4:0]  agu_idx;
   logic [4:0]  agu_disp;
   logic        agu_disp_ok;
   logic [1:0]  agu_size;
   logic [31:0] ea;
   logic        ea_valid;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [31:0] wb_data;
   logic [4:0]  obs_idx;
   logic [31:0] obs_data;

   int checks = 0;
   int failures = 0;
   logic [31:0] model [32];

   always #(CLK_PERIOD/2) clk = ~clk;

   ptr_agu uut (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .agu_stb(agu_stb), .agu_mode(agu_mode), .agu_idx(agu_idx),
      .agu_disp(agu_disp), .agu_disp_ok(agu_disp_ok), .agu_size(agu_size),
      .ea(ea), .ea_valid(ea_valid), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
      .obs_idx(obs_idx), .obs_data(obs_data)
   );

   function automatic logic [31:0] f_step(input logic [4:0] d, input logic ok, input logic [1:0] sz);
      logic [31:0] u = ok ? {27'd0, d} : 32'd1;
      return (sz == 2'd0) ? u : (sz == 2'd1) ? (u << 1) : (u << 2);
   endfunction

   function automatic logic f_has_wb(input logic [2:0] m);
      return (m >= 3'd1 && m <= 3'd4);
   endfunction

   function automatic logic [31:0] f_new(input logic [2:0] m, input logic [31:0] p, input logic [31:0] s);
      if (m == 3'd1 || m == 3'd3) return p + s;
      if (m == 3'd2 || m == 3'd4) return p - s;
      return p;
   endfunction

   function automatic logic [31:0] f_ea(input logic [2:0] m, input logic [31:0] p, input logic [31:0] s);
      case (m)
         3'd3:    return p + s;
         3'd4:    return p - s;
         3'd5:    return p + s;
         default: return p;
      endcase
   endfunction

   function automatic string f_req(input logic [2:0] m);
      case (m)
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One cycle: optional request plus optional load, checks outputs, updates model.
   task automatic cycle(input logic stb, input logic [2:0] m, input logic [4:0] idx,
                        input logic [4:0] d, input logic ok, input logic [1:0] sz,
                        input logic le, input logic [4:0] li, input logic [31:0] ldv,
                        input logic [4:0] oi);
      logic [31:0] s, p, nv;
      @(negedge clk);
      agu_stb = stb; agu_mode = m; agu_idx = idx; agu_disp = d; agu_disp_ok = ok; agu_size = sz;
      ld_en = le; ld_idx = li; ld_data = ldv; obs_idx = oi;
      #1;
      s = f_step(d, ok, sz);
      p = model[idx];
      nv = f_new(m, p, s);
      chk("R11 observe", obs_data, model[oi]);
      if (stb) begin
         chk({f_req(m), " ea"}, ea, f_ea(m, p, s));
         chk("R12 valid", {31'd0, ea_valid}, 32'd1);
         chk({f_req(m), " wb_en"}, {31'd0, wb_en}, {31'd0, f_has_wb(m)});
         if (f_has_wb(m)) begin
            chk({f_req(m), " wb_data"}, wb_data, nv);
            chk("R11 wb_idx", {27'd0, wb_idx}, {27'd0, idx});
         end
      end else begin
         chk("R12 idle valid", {31'd0, ea_valid}, 32'd0);
         chk("R12 idle wb", {31'd0, wb_en}, 32'd0);
      end
      @(posedge clk);
      if (stb && f_has_wb(m)) model[idx] = nv;
      if (le) model[li] = ldv;
   endtask

   task automatic idle_obs(input logic [4:0] oi, input string req, input logic [31:0] exp);
      @(negedge clk);
      agu_stb = 0; ld_en = 0; obs_idx = oi;
      #1;
      chk(req, obs_data, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unsigned seed = 32'h5eed_1234;
      void'($urandom(seed));
      rst_n = 0; ld_en = 0; ld_idx = 0; ld_data = 0; agu_stb = 0; agu_mode = 0;
      agu_idx = 0; agu_disp = 0; agu_disp_ok = 0; agu_size = 0; obs_idx = 0;
      for (int i = 0; i < 32; i++) model[i] = 32'd0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1: reset state
      for (int i = 0; i < 32; i++) idle_obs(5'(i), "R1 reset", 32'd0);

      // R2 / R11: load and bank separation (0 vs 16)
      cycle(0, 0, 0, 0, 0, 0, 1, 5'd0, 32'h0000_1000, 0);
      cycle(0, 0, 0, 0, 0, 0, 1, 5'd16, 32'h0000_2000, 0);
      idle_obs(5'd0, "R2 load r0", 32'h0000_1000);
      idle_obs(5'd16, "R11 bank r16", 32'h0000_2000);

      // R9: default displacement and scaling
      cycle(1, 3'd1, 5'd0, 5'd9, 0, 2'd2, 0, 0, 0, 0);  // default disp, word -> +4
      idle_obs(5'd0, "R9 default step", 32'h0000_1004);
      cycle(1, 3'd1, 5'd0, 5'd3, 1, 2'd1, 0, 0, 0, 0);  // 3 halves -> +6
      idle_obs(5'd0, "R9 half scale", 32'h0000_100a);
      cycle(1, 3'd3, 5'd0, 5'd3, 1, 2'd3, 0, 0, 0, 0);  // size 3 as word -> +12
      idle_obs(5'd0, "R9 size3 scale", 32'h0000_1016);

      // R8: pre-offset leaves pointer
      cycle(1, 3'd5, 5'd16, 5'd5, 1, 2'd0, 0, 0, 0, 16);
      idle_obs(5'd16, "R8 unchanged", 32'h0000_2000);

      // R3: codes 6 and 7 behave as indirect
      cycle(1, 3'd6, 5'd16, 5'd5, 1, 2'd0, 0, 0, 0, 16);
      cycle(1, 3'd7, 5'd16, 5'd5, 1, 2'd0, 0, 0, 0, 16);

      // R10: wrap both directions
      cycle(0, 0, 0, 0, 0, 0, 1, 5'd7, 32'hFFFF_FFFE, 7);
      cycle(1, 3'd1, 5'd7, 5'd1, 1, 2'd2, 0, 0, 0, 7);
      idle_obs(5'd7, "R10 wrap up", 32'h0000_0002);
      cycle(1, 3'd4, 5'd9, 5'd1, 1, 2'd0, 0, 0, 0, 9);
      idle_obs(5'd9, "R10 wrap down", 32'hFFFF_FFFF);

      // R11: back-to-back on same register
      cycle(1, 3'd2, 5'd20, 5'd2, 1, 2'd0, 0, 0, 0, 20);
      cycle(1, 3'd2, 5'd20, 5'd2, 1, 2'd0, 0, 0, 0, 20);
      idle_obs(5'd20, "R11 back to back", 32'hFFFF_FFFC);

      // R2: load and writeback to same register, load wins
      cycle(1, 3'd3, 5'd5, 5'd4, 1, 2'd0, 1, 5'd5, 32'hCAFE_0000, 5);
      idle_obs(5'd5, "R2 load wins", 32'hCAFE_0000);
      // load to other register in same bank while writeback
      cycle(1, 3'd1, 5'd5, 5'd1, 1, 2'd0, 1, 5'd6, 32'h0000_0600, 6);
      idle_obs(5'd5, "R2 wb concurrent", 32'hCAFE_0001);
      idle_obs(5'd6, "R2 load concurrent", 32'h0000_0600);

      // random mix
      for (int n = 0; n < 600; n++) begin
         cycle(($urandom % 8) != 0, 3'($urandom % 8), 5'($urandom), 5'($urandom),
               ($urandom % 4) != 0, 2'($urandom), ($urandom % 4) == 0, 5'($urandom),
               $urandom, 5'($urandom));
      end
      for (int i = 0; i < 32; i++) idle_obs(5'(i), "R11 final", model[i]);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule